// File: doc/BRIEF.md
# Encoded Ratio Clock Divider

The block divides a fast source clock by an integer N and drives the result on a single output clock. N is not given as a plain binary number. A short code carries two fields. The low two bits pick an odd or small base value, and the upper bits pick a power-of-two scale. A table-select input chooses between two sets of base values, so the same code can mean two different ratios.

Odd ratios keep an exact 50% duty. To do this, the divided waveform is built from a rising-edge state register and a copy of it taken on the falling edge, which gives the output half-cycle resolution. The output can also be inverted or stopped.

Every setting comes from register inputs and is copied into shadow state only at the rising source edge that closes the current output period. Because of this, a change of ratio, table, polarity or enable never produces a shortened pulse. A stopped output rests low. When it is started again, it begins a fresh, full-length period.

Top module: `enc_ratio_clkdiv`

## Requirements
- R1: With alt_table_i = 0, ratio_code_i[1:0] = 00, 01, 10, 11 selects base 2, 3, 5, 7, and ratio_code_i[3:2] = 00, 01, 10, 11 multiplies that base by 1, 2, 4, 8. The output period is N source cycles, so this table covers /2 to /56.
- R2: With alt_table_i = 1, the same base field selects 4, 3, 5, 9 and the same scale applies. This table covers /3 to /72.
- R3: For an even N, the output is high for N/2 source cycles and low for N/2 source cycles.
- R4: For an odd N, the output is high for exactly N half source cycles and low for exactly N half source cycles. The high phase begins on a falling source edge.
- R5: With invert_i = 1, the waveform is the complement of the running waveform. After a start from idle with an even N, the output stays low for N half cycles and then goes high for N half cycles. High and low lengths are the same as in R3 and R4.
- R6: Clearing enable_i lets the current period finish at full length. After that period the output stays low for as long as enable_i is 0.
- R7: Setting enable_i from idle starts a period at the first rising source edge that samples it. A non-inverted output rises at that edge when N is even, or at the following falling edge when N is odd. The first high phase is a full N half cycles.
- R8: A change of ratio_code_i, alt_table_i or invert_i takes effect only at the rising edge that ends the current period. The period in progress completes at the old ratio.
- R9: While rst_src_ni is low, the output is low. After release, the first period starts at the first rising source edge and uses the settings presented at that edge. The register bank that feeds the block resets to code 0101 (/6), invert 0 and enable 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src_i | input | 1 | Fast source clock; both edges are used |
| rst_src_ni | input | 1 | Asynchronous active-low reset |
| ratio_code_i | input | SCALE_W+2 (4) | Ratio code: bits [1:0] select the base, the upper bits select the scale |
| alt_table_i | input | 1 | 0 selects the primary base set, 1 selects the alternate base set |
| invert_i | input | 1 | 1 inverts the divided output |
| enable_i | input | 1 | 1 runs the output, 0 stops it low at the end of the period |
| clk_div_o | output | 1 | Divided output clock |

## Verification
All inputs are sampled at the rising source edge that ends a period. The output for a new setting therefore appears at that edge for an even N, half a source cycle later for an odd N, and never before the old period has run out. The bench samples the output a quarter source period after every source edge, so each sample falls in the middle of a half cycle. It measures high and low phases as counts of half cycles. After every setting change it lets the old period and one full new period run out before it measures. The start, stop and mid-period tests count forward from the exact sampling edge, so the expected first level and phase length are known in advance.

// File: rtl/ecd_pkg.sv
`timescale 1ns/1ps
package ecd_pkg;

   // Width of the base-select field at the bottom of the ratio code.
   localparam int unsigned ECD_SEL_W = 2;

   // Base divisor for one base-select value in either table.
   function automatic int unsigned ecd_base(input logic alt, input logic [ECD_SEL_W-1:0] sel);
      int unsigned b;
      case (sel)
         2'd0:    b = alt ? 4 : 2;
         2'd1:    b = 3;
         2'd2:    b = 5;
         default: b = alt ? 9 : 7;
      endcase
      return b;
   endfunction

   // Full divide ratio: base shifted by the scale field.
   function automatic int unsigned ecd_divisor(input logic alt, input logic [ECD_SEL_W-1:0] sel,
                                               input int unsigned shift);
      return ecd_base(alt, sel) << shift;
   endfunction

   // Largest ratio a configuration can reach.
   function automatic int unsigned ecd_max_div(input int unsigned scale_w, input bit alt_en);
      return (alt_en ? 32'd9 : 32'd7) << ((32'd1 << scale_w) - 32'd1);
   endfunction

endpackage

// File: rtl/ecd_ratio_decode.sv
`timescale 1ns/1ps
module ecd_ratio_decode
   import ecd_pkg::*;
#(
   parameter int unsigned SCALE_W   = 2,
   parameter bit          ALT_TABLE = 1'b1,
   parameter int unsigned CNT_W     = 7
) (
   input  logic [SCALE_W+ECD_SEL_W-1:0] code_i,
   input  logic                         alt_i,
   output logic [CNT_W-1:0]             div_o,
   output logic [CNT_W-1:0]             half_o,
   output logic                         odd_o
);
   localparam int unsigned CODE_W = SCALE_W + ECD_SEL_W;

   logic                 alt_eff;
   logic [ECD_SEL_W-1:0] base_sel;
   logic [SCALE_W-1:0]   scale_sel;

   assign base_sel  = code_i[ECD_SEL_W-1:0];
   assign scale_sel = code_i[CODE_W-1:ECD_SEL_W];

   // The alternate base set is only built when the option asks for it.
   generate
      if (ALT_TABLE) begin : g_two_tables
         assign alt_eff = alt_i;
      end else begin : g_primary_only
         logic unused_alt;
         assign unused_alt = alt_i;
         assign alt_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      div_o  = CNT_W'(ecd_divisor(alt_eff, base_sel, 32'(scale_sel)));
      // Rising-edge high length: ceil(N/2); odd ratios are trimmed by half a cycle later.
      half_o = (div_o >> 1) + CNT_W'(div_o[0]);
      odd_o  = div_o[0];
   end

endmodule

// File: rtl/ecd_period_ctrl.sv
`timescale 1ns/1ps
module ecd_period_ctrl #(
   parameter int unsigned CNT_W   = 7,
   parameter int unsigned MAX_DIV = 72,
   parameter int unsigned RST_DIV = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] div_i,
   input  logic [CNT_W-1:0] half_i,
   input  logic             odd_i,
   input  logic             inv_i,
   input  logic             en_i,
   output logic             pos_o,
   output logic             odd_o,
   output logic             inv_o,
   output logic             run_o
);
   logic [CNT_W-1:0] cnt_q, div_q, half_q;
   logic             odd_q, inv_q, run_q, pos_q;
   logic [CNT_W-1:0] cnt_n, div_n, half_n;
   logic             odd_n, inv_n, run_n, pos_n;
   logic             last, boundary;

   assign last     = (cnt_q == div_q - 1'b1);
   // While idle every edge is a boundary, so a start needs no wait.
   assign boundary = !run_q || last;

   always_comb begin
      if (boundary) begin
         cnt_n  = '0;
         div_n  = div_i;
         half_n = half_i;
         odd_n  = odd_i;
         inv_n  = inv_i;
         run_n  = en_i;
      end else begin
         cnt_n  = cnt_q + 1'b1;
         div_n  = div_q;
         half_n = half_q;
         odd_n  = odd_q;
         inv_n  = inv_q;
         run_n  = run_q;
      end
      pos_n = run_n && ((cnt_n < half_n) ^ inv_n);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         div_q  <= CNT_W'(RST_DIV);
         half_q <= CNT_W'((RST_DIV + 1) / 2);
         odd_q  <= (RST_DIV % 2) == 1;
         inv_q  <= 1'b0;
         run_q  <= 1'b0;
         pos_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_n;
         div_q  <= div_n;
         half_q <= half_n;
         odd_q  <= odd_n;
         inv_q  <= inv_n;
         run_q  <= run_n;
         pos_q  <= pos_n;
      end
   end

   assign pos_o = pos_q;
   assign odd_o = odd_q;
   assign inv_o = inv_q;
   assign run_o = run_q;

   // R8 / R6: nothing is reloaded and the output keeps running until the period ends
   a_r8_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && !last) |=> ($stable(div_q) && $stable(half_q) && $stable(odd_q)
                            && $stable(inv_q) && run_q));

   // R1 / R2: an active ratio stays within the table span and the count within it
   a_r1_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |-> ((div_q >= CNT_W'(2)) && (div_q <= CNT_W'(MAX_DIV)) && (cnt_q < div_q)));

endmodule

// File: rtl/ecd_edge_shaper.sv
`timescale 1ns/1ps
module ecd_edge_shaper #(
   parameter bit DUAL_EDGE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pos_i,
   input  logic odd_i,
   input  logic inv_i,
   output logic clk_o
);
   generate
      if (DUAL_EDGE) begin : g_dual
         logic neg_q;
         logic mix;

         always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) neg_q <= 1'b0;
            else         neg_q <= pos_i;
         end

         // AND trims the leading half cycle; OR (inverted) stretches the trailing one.
         assign mix   = inv_i ? (pos_i | neg_q) : (pos_i & neg_q);
         assign clk_o = odd_i ? mix : pos_i;

         // R4: the falling-edge copy trails the rising-edge state by exactly half a cycle
         a_r4_half_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
            neg_q == pos_i);
      end else begin : g_single
         logic unused_sel;
         assign unused_sel = odd_i ^ inv_i;
         assign clk_o      = pos_i;
      end
   endgenerate

endmodule

// File: rtl/enc_ratio_clkdiv.sv
`timescale 1ns/1ps
module enc_ratio_clkdiv
   import ecd_pkg::*;
#(
   parameter int unsigned SCALE_W   = 2,
   parameter bit          ALT_TABLE = 1'b1,
   parameter bit          DUAL_EDGE = 1'b1,
   parameter int unsigned RST_CODE  = 5
) (
   input  logic               clk_src_i,
   input  logic               rst_src_ni,
   input  logic [SCALE_W+1:0] ratio_code_i,
   input  logic               alt_table_i,
   input  logic               invert_i,
   input  logic               enable_i,
   output logic               clk_div_o
);
   localparam int unsigned CODE_W  = SCALE_W + ECD_SEL_W;
   localparam int unsigned MAX_DIV = ecd_max_div(SCALE_W, ALT_TABLE);
   localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);
   localparam int unsigned RST_DIV = ecd_divisor(1'b0, 2'(RST_CODE), RST_CODE >> ECD_SEL_W);

   generate
      if (SCALE_W < 1 || SCALE_W > 4) begin : g_bad_scale
         $error("enc_ratio_clkdiv: SCALE_W must lie in 1..4");
      end
      if (RST_CODE >= (32'd1 << CODE_W)) begin : g_bad_rst_code
         $error("enc_ratio_clkdiv: RST_CODE does not fit the code width");
      end
   endgenerate

   logic [CNT_W-1:0] dec_div, dec_half;
   logic             dec_odd;
   logic             pos_w, odd_w, inv_w, run_w;

   ecd_ratio_decode #(
      .SCALE_W  (SCALE_W),
      .ALT_TABLE(ALT_TABLE),
      .CNT_W    (CNT_W)
   ) i_decode (
      .code_i(ratio_code_i),
      .alt_i (alt_table_i),
      .div_o (dec_div),
      .half_o(dec_half),
      .odd_o (dec_odd)
   );

   ecd_period_ctrl #(
      .CNT_W  (CNT_W),
      .MAX_DIV(MAX_DIV),
      .RST_DIV(RST_DIV)
   ) i_period (
      .clk_i (clk_src_i),
      .rst_ni(rst_src_ni),
      .div_i (dec_div),
      .half_i(dec_half),
      .odd_i (dec_odd),
      .inv_i (invert_i),
      .en_i  (enable_i),
      .pos_o (pos_w),
      .odd_o (odd_w),
      .inv_o (inv_w),
      .run_o (run_w)
   );

   ecd_edge_shaper #(
      .DUAL_EDGE(DUAL_EDGE)
   ) i_shaper (
      .clk_i (clk_src_i),
      .rst_ni(rst_src_ni),
      .pos_i (pos_w),
      .odd_i (odd_w),
      .inv_i (inv_w),
      .clk_o (clk_div_o)
   );

   // R6: once idle for a full cycle, the output rests low whatever the polarity
   a_r6_idle_low: assert property (@(posedge clk_src_i) disable iff (!rst_src_ni)
      (!run_w && !$past(run_w)) |-> !clk_div_o);

endmodule

// File: tb/test_enc_ratio_clkdiv.sv
`timescale 1ns/1ps
module test_enc_ratio_clkdiv;

   // {invert, alt table, code[3:0], expected N[6:0]}
   localparam int NVEC = 14;
   localparam logic [12:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 4'b0000, 7'd2},
      {1'b0, 1'b0, 4'b0001, 7'd3},
      {1'b0, 1'b0, 4'b0010, 7'd5},
      {1'b0, 1'b0, 4'b0011, 7'd7},
      {1'b0, 1'b0, 4'b0101, 7'd6},
      {1'b0, 1'b0, 4'b1010, 7'd20},
      {1'b0, 1'b0, 4'b1111, 7'd56},
      {1'b0, 1'b0, 4'b1011, 7'd28},
      {1'b0, 1'b1, 4'b0000, 7'd4},
      {1'b0, 1'b1, 4'b0011, 7'd9},
      {1'b0, 1'b1, 4'b1111, 7'd72},
      {1'b0, 1'b1, 4'b0110, 7'd10},
      {1'b1, 1'b0, 4'b0010, 7'd5},
      {1'b1, 1'b1, 4'b1001, 7'd12}
   };

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] code  = 4'b0101;
   logic       alt   = 1'b0;
   logic       inv   = 1'b0;
   logic       en    = 1'b1;
   logic       clk_div;
   logic       s     = 1'b0;
   int         n_chk  = 0;
   int         n_fail = 0;

   enc_ratio_clkdiv i_enc_ratio_clkdiv (
      .clk_src_i   (clk),
      .rst_src_ni  (rst_n),
      .ratio_code_i(code),
      .alt_table_i (alt),
      .invert_i    (inv),
      .enable_i    (en),
      .clk_div_o   (clk_div)
   );

   always #5 clk = ~clk;

   // One sample per half cycle, a quarter period after each edge.
   task automatic step();
      @(clk);
      #2.5;
      s = clk_div;
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_len(input logic lvl, output int n);
      n = 0;
      while (s == lvl && n < 400) begin
         n++;
         step();
      end
   endtask

   task automatic sync_high();
      int g;
      g = 0;
      while (s != 1'b0 && g < 400) begin g++; step(); end
      g = 0;
      while (s != 1'b1 && g < 400) begin g++; step(); end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int    hi, lo, hi2, lo2, quiet, nexp;
      string tag_p, tag_d;

      // R9: low during reset, first period right after release
      repeat (6) step();
      check("R9 low in reset", int'(s), 0);
      @(negedge clk);
      #2.5;
      rst_n = 1'b1;
      step();
      check("R9 first edge high", int'(s), 1);

      // Table of ratios: period and duty per entry
      for (int k = 0; k < NVEC; k++) begin
         inv  = VEC[k][12];
         alt  = VEC[k][11];
         code = VEC[k][10:7];
         nexp = int'(VEC[k][6:0]);
         repeat (300) step();
         sync_high();
         run_len(1'b1, hi);
         run_len(1'b0, lo);
         tag_p = alt ? "R2 period" : "R1 period";
         tag_d = inv ? "R5 duty" : ((nexp % 2) == 1 ? "R4 duty" : "R3 duty");
         check(tag_p, hi + lo, 2 * nexp);
         check(tag_d, hi, nexp);
      end

      // R6: stop requested at the start of a high phase
      inv  = 1'b0;
      alt  = 1'b0;
      code = 4'b0101;
      repeat (300) step();
      sync_high();
      en = 1'b0;
      run_len(1'b1, hi);
      check("R6 period completes", hi, 6);
      quiet = 0;
      for (int i = 0; i < 200; i++) begin
         step();
         if (s == 1'b0) quiet++;
      end
      check("R6 held low", quiet, 200);

      // R7: restart with an even ratio
      @(negedge clk);
      #2.5;
      en = 1'b1;
      step();
      check("R7 even rises at start edge", int'(s), 1);
      run_len(1'b1, hi);
      check("R7 even first high full", hi, 6);

      // R7: restart with an odd ratio
      en = 1'b0;
      code = 4'b0010;
      repeat (300) step();
      @(negedge clk);
      #2.5;
      en = 1'b1;
      step();
      check("R7 odd low at start edge", int'(s), 0);
      step();
      run_len(1'b1, hi);
      check("R7 odd first high full", hi, 5);

      // R5: inverted restart starts with a full low phase
      en = 1'b0;
      repeat (300) step();
      code = 4'b0101;
      inv  = 1'b1;
      @(negedge clk);
      #2.5;
      en = 1'b1;
      step();
      run_len(1'b0, lo);
      run_len(1'b1, hi);
      check("R5 inverted first low", lo, 6);
      check("R5 inverted first high", hi, 6);

      // R8: ratio change in the middle of a long period
      inv  = 1'b0;
      code = 4'b1111;
      repeat (300) step();
      sync_high();
      code = 4'b0000;
      run_len(1'b1, hi);
      run_len(1'b0, lo);
      run_len(1'b1, hi2);
      run_len(1'b0, lo2);
      check("R8 old high kept", hi, 56);
      check("R8 old low kept", lo, 56);
      check("R8 new high", hi2, 2);
      check("R8 new low", lo2, 2);

      summary();
      $finish;
   end

endmodule